// File: doc/BRIEF.md
# Save/Restore Sequencer for a Shadowed SRAM

This block decides when a volatile SRAM array is copied into its nonvolatile shadow array (a save) and when the shadow is copied back (a restore). While either runs, it blocks every SRAM access. It also asserts a shared active-low busy line, which other agents can pull low to ask for a save. Each save is two timed phases, erase then program. Each restore is two timed phases, clear then transfer. Every phase length is a parameter given in clock cycles.

A restore starts by itself whenever the supply-good flag returns, and also after reset. A save needs at least one SRAM write to have landed since the last save or restore; an internal dirty flag records this. When another agent pulls the busy line low while nothing is dirty, the block only blocks access until the line is released. After a save ends, access stays blocked until the line is high, and for a lockout period after that.

Top module: `nv_shadow_seq`

## Requirements
- R1: After reset, and whenever `supply_ok_i` is low, the block sits in a powered-down state. In this state `inhibit_o`=1, `hs_drive_o`=0 and all phase strobes are 0. The first cycle sampled with `supply_ok_i`=1 starts a restore.
- R2: For every cycle of a save or restore phase, `hs_drive_o`=1 and `inhibit_o`=1. `hs_drive_o` returns to 0 in the cycle after the last phase cycle.
- R3: A save raises `erase_o` for ERASE_CYC cycles and then `program_o` for PROG_CYC cycles. At most one strobe is high in any cycle.
- R4: A restore raises `clear_o` for CLEAR_CYC cycles and then `xfer_o` for XFER_CYC cycles.
- R5: When `hs_ext_low_i`=1 while idle and the dirty flag is set, a save starts in the next cycle.
- R6: When `hs_ext_low_i`=1 while idle and the dirty flag is clear, `hs_drive_o` stays 0. `inhibit_o` is 1 for as long as `hs_ext_low_i` is 1, and falls in the first cycle after release, with no lockout.
- R7: After a save, `inhibit_o` stays 1 while `hs_ext_low_i` is 1. After the line is released, it stays 1 for a further LOCK_CYC cycles.
- R8: A `sram_wr_i` pulse sets the dirty flag only while `inhibit_o`=0. A completed save clears the flag, and so does a completed restore.
- R9: A software save request with the dirty flag set has priority over a software restore request in the same cycle. Requests that arrive while not idle are dropped.
- R10: `done_o` is a one-cycle pulse. It appears in the cycle after the final phase cycle of a save or a restore.
- R11: If `supply_ok_i` falls during any operation, the operation is abandoned. On the next cycle the block is in the R1 state.
- R12: A software save request with the dirty flag clear is ignored: no strobe and no busy drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above switch threshold |
| sram_wr_i | input | 1 | SRAM write attempted this cycle |
| sw_store_i | input | 1 | Software save request |
| sw_recall_i | input | 1 | Software restore request |
| hs_ext_low_i | input | 1 | Busy line pulled low by another agent |
| hs_drive_o | output | 1 | Drive busy line low |
| inhibit_o | output | 1 | Block all SRAM reads and writes |
| erase_o | output | 1 | Erase phase active |
| program_o | output | 1 | Program phase active |
| clear_o | output | 1 | SRAM clear phase active |
| xfer_o | output | 1 | Shadow-to-SRAM transfer phase active |
| done_o | output | 1 | Save or restore finished |

## Verification
The hardest case to reach is a save that another agent triggers and then keeps holding past the end of the program phase. In that case the lockout must wait for the line's release, not for the end of programming. The bench sets the dirty flag with a write, pulls the external line low, and holds it through the whole save plus several extra cycles. It then releases the line and counts the lockout cycles that follow.

A second case is a write attempted during an externally held line with nothing dirty. Its only visible effect is whether a later external pull starts a save. The bench makes that pull and checks that no save starts.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [3:0] {
    S_OFF, S_IDLE, S_ERASE, S_PROG, S_CLEAR, S_XFER, S_HOLD, S_WAIT_REL, S_LOCK
  } seq_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_STORE, OP_RECALL, OP_HOLD} seq_op_e;
endpackage

// File: rtl/nv_req_arb.sv
module nv_req_arb
  import nv_seq_pkg::*;
(
  input  logic    ext_low_i,
  input  logic    dirty_i,
  input  logic    sw_store_i,
  input  logic    sw_recall_i,
  output seq_op_e op_o
);
  always_comb begin
    if (ext_low_i)                    op_o = dirty_i ? OP_STORE : OP_HOLD;
    else if (sw_store_i && dirty_i)   op_o = OP_STORE;
    else if (sw_recall_i)             op_o = OP_RECALL;
    else                              op_o = OP_NONE;
  end
endmodule

// File: rtl/nv_wr_latch.sv
module nv_wr_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/nv_op_timer.sv
module nv_op_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq
  import nv_seq_pkg::*;
#(
  parameter int unsigned ERASE_CYC = 4,
  parameter int unsigned PROG_CYC  = 6,
  parameter int unsigned CLEAR_CYC = 3,
  parameter int unsigned XFER_CYC  = 5,
  parameter int unsigned LOCK_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic sram_wr_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic hs_ext_low_i,
  output logic hs_drive_o,
  output logic inhibit_o,
  output logic erase_o,
  output logic program_o,
  output logic clear_o,
  output logic xfer_o,
  output logic done_o
);
  localparam int unsigned MAX_A = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned MAX_B = (CLEAR_CYC > XFER_CYC) ? CLEAR_CYC : XFER_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC = (MAX_C > LOCK_CYC) ? MAX_C : LOCK_CYC;
  localparam int unsigned CW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CW-1:0] LD_ERASE = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] LD_PROG  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] LD_CLEAR = CW'(CLEAR_CYC - 1);
  localparam logic [CW-1:0] LD_XFER  = CW'(XFER_CYC - 1);
  localparam logic [CW-1:0] LD_LOCK  = CW'(LOCK_CYC - 1);

  seq_state_e state_q, state_d;
  seq_op_e    op;
  logic          dirty, tmr_zero, tmr_load, op_end, done_q;
  logic [CW-1:0] tmr_val;

  nv_req_arb u_arb (
    .ext_low_i  (hs_ext_low_i),
    .dirty_i    (dirty),
    .sw_store_i (sw_store_i),
    .sw_recall_i(sw_recall_i),
    .op_o       (op)
  );

  nv_op_timer #(.W(CW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  // final cycle of a save or restore
  assign op_end = supply_ok_i && tmr_zero && (state_q == S_PROG || state_q == S_XFER);

  nv_wr_latch u_dirty (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sram_wr_i && !inhibit_o),
    .clr_i (op_end),
    .q_o   (dirty)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!supply_ok_i) begin
      state_d = S_OFF;
    end else begin
      unique case (state_q)
        S_OFF: begin
          state_d = S_CLEAR; tmr_load = 1'b1; tmr_val = LD_CLEAR;
        end
        S_IDLE: begin
          unique case (op)
            OP_STORE:  begin state_d = S_ERASE; tmr_load = 1'b1; tmr_val = LD_ERASE; end
            OP_RECALL: begin state_d = S_CLEAR; tmr_load = 1'b1; tmr_val = LD_CLEAR; end
            OP_HOLD:   state_d = S_HOLD;
            default:   state_d = S_IDLE;
          endcase
        end
        S_ERASE: if (tmr_zero) begin
          state_d = S_PROG; tmr_load = 1'b1; tmr_val = LD_PROG;
        end
        S_PROG: if (tmr_zero) begin
          if (hs_ext_low_i) state_d = S_WAIT_REL;
          else begin state_d = S_LOCK; tmr_load = 1'b1; tmr_val = LD_LOCK; end
        end
        S_CLEAR: if (tmr_zero) begin
          state_d = S_XFER; tmr_load = 1'b1; tmr_val = LD_XFER;
        end
        S_XFER:     if (tmr_zero) state_d = S_IDLE;
        S_HOLD:     if (!hs_ext_low_i) state_d = S_IDLE;
        S_WAIT_REL: if (!hs_ext_low_i) begin
          state_d = S_LOCK; tmr_load = 1'b1; tmr_val = LD_LOCK;
        end
        S_LOCK:     if (tmr_zero) state_d = S_IDLE;
        default:    state_d = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= op_end;
    end
  end

  assign erase_o    = (state_q == S_ERASE);
  assign program_o  = (state_q == S_PROG);
  assign clear_o    = (state_q == S_CLEAR);
  assign xfer_o     = (state_q == S_XFER);
  assign hs_drive_o = erase_o || program_o || clear_o || xfer_o;
  assign inhibit_o  = (state_q != S_IDLE) || hs_ext_low_i || !supply_ok_i;
  assign done_o     = done_q;

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_o, program_o, clear_o, xfer_o}));
  a_r3_prog_after_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(program_o) |-> $past(erase_o));
  a_r4_xfer_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_o) |-> $past(clear_o));
  a_r2_drive_starts_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_drive_o) |-> (erase_o || clear_o));
  a_r10_done_follows_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(program_o) || $past(xfer_o)));
  a_r8_done_clears_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dirty);
  a_r11_supply_loss_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !hs_drive_o);
endmodule

// File: tb/nv_shadow_seq_tb_top.sv
`timescale 1ns/100ps
module nv_shadow_seq_tb_top;
  localparam int ERASE_CYC = 4, PROG_CYC = 6, CLEAR_CYC = 3, XFER_CYC = 5, LOCK_CYC = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic supply_ok = 1'b0, sram_wr = 1'b0, sw_store = 1'b0, sw_recall = 1'b0, ext_low = 1'b0;
  logic hs_drive, inhibit, erase, prog, clr, xfer, done;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  nv_shadow_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CLEAR_CYC(CLEAR_CYC),
                  .XFER_CYC(XFER_CYC), .LOCK_CYC(LOCK_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .sram_wr_i(sram_wr),
    .sw_store_i(sw_store), .sw_recall_i(sw_recall), .hs_ext_low_i(ext_low),
    .hs_drive_o(hs_drive), .inhibit_o(inhibit), .erase_o(erase), .program_o(prog),
    .clear_o(clr), .xfer_o(xfer), .done_o(done));

  // {write first, req[1:0] (1 save, 2 restore, 3 both), expected[1:0] (0 none, 1 save, 2 restore)}
  localparam logic [4:0] VEC [7] = '{
    5'b1_01_01, 5'b0_01_00, 5'b0_10_10, 5'b1_11_01,
    5'b1_10_10, 5'b0_01_00, 5'b0_11_10 };

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(); sram_wr = 1'b1; tick(); sram_wr = 1'b0; endtask

  task automatic run_op(output int ne, output int np, output int nc, output int nx,
                        output int nd, output int nl, output int ndn);
    ne = 0; np = 0; nc = 0; nx = 0; nd = 0; nl = 0; ndn = 0;
    for (int i = 0; i < 200; i++) begin
      ne += int'(erase); np += int'(prog); nc += int'(clr); nx += int'(xfer);
      nd += int'(hs_drive); nl += int'(inhibit && !hs_drive); ndn += int'(done);
      if (!inhibit) break;
      tick();
    end
  endtask

  task automatic check_op(string tag, int kind);
    int ne, np, nc, nx, nd, nl, ndn;
    run_op(ne, np, nc, nx, nd, nl, ndn);
    chk({tag, " erase cycles R3"}, ne, kind == 1 ? ERASE_CYC : 0);
    chk({tag, " program cycles R3"}, np, kind == 1 ? PROG_CYC : 0);
    chk({tag, " clear cycles R4"}, nc, kind == 2 ? CLEAR_CYC : 0);
    chk({tag, " xfer cycles R4"}, nx, kind == 2 ? XFER_CYC : 0);
    chk({tag, " drive cycles R2"}, nd,
        kind == 1 ? ERASE_CYC + PROG_CYC : kind == 2 ? CLEAR_CYC + XFER_CYC : 0);
    chk({tag, " lockout cycles R7"}, nl, kind == 1 ? LOCK_CYC : 0);
    chk({tag, " done pulses R10"}, ndn, kind == 0 ? 0 : 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    // R1: reset/powered-down state
    #12 rst_ni = 1'b1;
    tick(); tick();
    chk("R1 inhibit while supply low", int'(inhibit), 1);
    chk("R1 no drive while supply low", int'(hs_drive), 0);
    chk("R1 strobes off", int'({erase, prog, clr, xfer}), 0);
    supply_ok = 1'b1; tick();
    check_op("R1 power-up restore", 2);

    // table walk: R8 R9 R12
    foreach (VEC[k]) begin
      tick();
      if (VEC[k][4]) do_write();
      sw_store = VEC[k][2]; sw_recall = VEC[k][3];
      tick();
      sw_store = 1'b0; sw_recall = 1'b0;
      check_op($sformatf("vec%0d R9 R12 R8", k), int'(VEC[k][1:0]));
    end

    // R5 R7: external save held past program end
    tick(); do_write();
    ext_low = 1'b1; tick();
    chk("R5 external save starts erase", int'(erase), 1);
    n = 0;
    while (hs_drive && n < 100) begin n++; tick(); end
    chk("R5 R2 external save drive cycles", n, ERASE_CYC + PROG_CYC);
    for (int i = 0; i < 5; i++) begin
      chk("R7 inhibit while line held", int'(inhibit), 1);
      chk("R7 no drive while line held", int'(hs_drive), 0);
      tick();
    end
    ext_low = 1'b0; tick();
    n = 0;
    while (inhibit && n < 100) begin n++; tick(); end
    chk("R7 lockout after release", n, LOCK_CYC);

    // R6 R8: external pull with nothing dirty; blocked write
    ext_low = 1'b1; #0.1;
    chk("R6 inhibit follows line", int'(inhibit), 1);
    tick(); tick();
    chk("R6 no drive when clean", int'(hs_drive), 0);
    do_write();
    tick();
    chk("R6 still inhibited", int'(inhibit), 1);
    ext_low = 1'b0; tick();
    chk("R6 no lockout after release", int'(inhibit), 0);
    ext_low = 1'b1; tick(); tick();
    chk("R8 blocked write left flag clear", int'(hs_drive), 0);
    ext_low = 1'b0; tick();

    // R9: request during busy dropped
    do_write();
    sw_store = 1'b1; tick(); sw_store = 1'b0;
    tick(); sw_recall = 1'b1; tick(); sw_recall = 1'b0;
    n = 0;
    while (inhibit && n < 100) begin n++; tick(); end
    tick(); tick();
    chk("R9 busy restore request dropped", int'(hs_drive || clr), 0);

    // R11: supply loss mid-save, then automatic restore (R1)
    do_write();
    sw_store = 1'b1; tick(); sw_store = 1'b0;
    tick(); tick();
    supply_ok = 1'b0; tick();
    chk("R11 drive released", int'(hs_drive), 0);
    chk("R11 inhibited", int'(inhibit), 1);
    chk("R11 strobes off", int'({erase, prog, clr, xfer}), 0);
    tick();
    supply_ok = 1'b1; tick();
    check_op("R1 supply-return restore", 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule